// File: doc/BRIEF.md
# Per-Channel Overcurrent Monitor

The block watches up to four current channels for overcurrent. An upstream RMS engine presents a fresh half-cycle RMS magnitude for every channel together with a one-cycle update strobe. On each strobe, every channel whose enable bit is set is compared against a programmable limit. The limit is given in full-scale RMS units, and the block scales it to the half-cycle domain by dropping its five least significant bits.

A channel that trips the limit raises its own indication bit and the shared overcurrent flag. Its RMS value is also copied into that channel's capture register. Both flags stay set until software clears them by writing ones. A channel that is disabled or quiet keeps its previous capture value. A single interrupt request line reports the shared flag whenever the interrupt enable is set.

Top module: `oc_monitor`

## Requirements
- R1: While reset is active and right after it, `oc_flag_o`, `oc_phase_o`, every capture value and `irq_o` are zero.
- R2: Channel i is bit i of `ch_en_i`, `oc_phase_o`, `clr_phase_i`, and slice [24*i+23:24*i] of `rms_i` and `cap_o`. If `upd_vld_i` is high, channel i is enabled and its RMS is above the threshold, then after that clock edge `oc_phase_o[i]` and `oc_flag_o` are set.
- R3: The comparison is strictly greater-than, so an RMS equal to the threshold causes no trip.
- R4: A channel whose enable bit is clear never sets its indication bit and never changes its capture value, whatever its RMS.
- R5: A tripping channel has its RMS value written into its capture register at the same edge. A channel that does not trip keeps its capture register unchanged.
- R6: A cycle with `upd_vld_i` low evaluates nothing: no flag is set and no capture changes.
- R7: The threshold is `lim_i >> 5`, so the five low bits of `lim_i` have no effect.
- R8: Indication bits and the shared flag are sticky. Later updates without overcurrent leave them set.
- R9: A one in `clr_phase_i[i]` clears `oc_phase_o[i]`, and a one in `clr_flag_i` clears `oc_flag_o`. A zero in either leaves the bit as it was.
- R10: When a clear and a new trip hit the same bit at the same edge, the bit ends up set.
- R11: `irq_o` is high exactly when `irq_en_i` is high and `oc_flag_o` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_vld_i | input | 1 | Strobe: new RMS values are present |
| rms_i | input | 96 | Half-cycle RMS values, 24 bits per channel |
| ch_en_i | input | 4 | Per-channel monitor enable |
| lim_i | input | 29 | Overcurrent limit in full-scale RMS units |
| irq_en_i | input | 1 | Interrupt enable |
| clr_phase_i | input | 4 | Write-1-to-clear for the indication bits |
| clr_flag_i | input | 1 | Write-1-to-clear for the shared flag |
| oc_flag_o | output | 1 | Sticky shared overcurrent flag |
| oc_phase_o | output | 4 | Sticky per-channel indication bits |
| cap_o | output | 96 | Captured RMS value per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- Indication bits never drop without a clear.
- A new indication bit only appears for an enabled channel on a strobe cycle.
- Any new indication bit comes with the shared flag.
- Captures hold still between strobes.
- A clear of the flag without a strobe takes effect.
- The request line never rises without its enable and the flag.

Some behaviours depend on exact values, and only the bench scenarios can show them:
- the strict equality boundary;
- the ignored low bits of the limit;
- the precise captured values;
- the priority of a new trip over a simultaneous clear.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int unsigned OC_NCH   = 4;
    localparam int unsigned OC_RMS_W = 24;
    localparam int unsigned OC_SHIFT = 5;
endpackage

// File: rtl/oc_chan_cmp.sv
module oc_chan_cmp #(
    parameter int unsigned RMS_W = oc_pkg::OC_RMS_W
) (
    input  logic [RMS_W-1:0] rms_i,
    input  logic [RMS_W-1:0] thr_i,
    input  logic             en_i,
    input  logic             vld_i,
    output logic             hit_o
);
    // strictly above the limit, only on an enabled channel during a strobe
    assign hit_o = vld_i & en_i & (rms_i > thr_i);
endmodule

// File: rtl/oc_status.sv
module oc_status #(
    parameter int unsigned NCH = oc_pkg::OC_NCH
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] hit_i,
    input  logic [NCH-1:0] clr_phase_i,
    input  logic           clr_flag_i,
    input  logic           irq_en_i,
    output logic           oc_flag_o,
    output logic [NCH-1:0] oc_phase_o,
    output logic           irq_o
);
    typedef struct packed {
        logic           flag;
        logic [NCH-1:0] phase;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a fresh trip wins over a clear at the same edge
        st_d.phase = (st_q.phase & ~clr_phase_i) | hit_i;
        st_d.flag  = (st_q.flag & ~clr_flag_i) | (|hit_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign oc_flag_o  = st_q.flag;
    assign oc_phase_o = st_q.phase;
    assign irq_o      = irq_en_i & st_q.flag;
endmodule

// File: rtl/oc_capture_bank.sv
module oc_capture_bank #(
    parameter int unsigned NCH   = oc_pkg::OC_NCH,
    parameter int unsigned RMS_W = oc_pkg::OC_RMS_W
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NCH-1:0]       hit_i,
    input  logic [NCH*RMS_W-1:0] rms_i,
    output logic [NCH*RMS_W-1:0] cap_o
);
    typedef struct packed {
        logic [NCH-1:0][RMS_W-1:0] cap;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        for (int i = 0; i < NCH; i++) begin
            if (hit_i[i]) cap_d.cap[i] = rms_i[i*RMS_W +: RMS_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign cap_o = cap_q.cap;
endmodule

// File: rtl/oc_monitor.sv
module oc_monitor #(
    parameter int unsigned NCH   = oc_pkg::OC_NCH,
    parameter int unsigned RMS_W = oc_pkg::OC_RMS_W,
    parameter int unsigned SHIFT = oc_pkg::OC_SHIFT,
    localparam int unsigned LIM_W = RMS_W + SHIFT
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 upd_vld_i,
    input  logic [NCH*RMS_W-1:0] rms_i,
    input  logic [NCH-1:0]       ch_en_i,
    input  logic [LIM_W-1:0]     lim_i,
    input  logic                 irq_en_i,
    input  logic [NCH-1:0]       clr_phase_i,
    input  logic                 clr_flag_i,
    output logic                 oc_flag_o,
    output logic [NCH-1:0]       oc_phase_o,
    output logic [NCH*RMS_W-1:0] cap_o,
    output logic                 irq_o
);
    logic [RMS_W-1:0] thr;
    logic [NCH-1:0]   hit;

    // scale the full-scale limit into the half-cycle RMS domain
    assign thr = lim_i[LIM_W-1:SHIFT];

    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        oc_chan_cmp #(.RMS_W(RMS_W)) u_cmp (
            .rms_i (rms_i[g*RMS_W +: RMS_W]),
            .thr_i (thr),
            .en_i  (ch_en_i[g]),
            .vld_i (upd_vld_i),
            .hit_o (hit[g])
        );
    end

    oc_status #(.NCH(NCH)) u_status (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hit_i       (hit),
        .clr_phase_i (clr_phase_i),
        .clr_flag_i  (clr_flag_i),
        .irq_en_i    (irq_en_i),
        .oc_flag_o   (oc_flag_o),
        .oc_phase_o  (oc_phase_o),
        .irq_o       (irq_o)
    );

    oc_capture_bank #(.NCH(NCH), .RMS_W(RMS_W)) u_cap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hit_i  (hit),
        .rms_i  (rms_i),
        .cap_o  (cap_o)
    );
endmodule

// File: rtl/oc_monitor_chk.sv
module oc_monitor_chk #(
    parameter int unsigned NCH   = oc_pkg::OC_NCH,
    parameter int unsigned RMS_W = oc_pkg::OC_RMS_W
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 upd_vld_i,
    input logic [NCH-1:0]       ch_en_i,
    input logic                 irq_en_i,
    input logic [NCH-1:0]       clr_phase_i,
    input logic                 clr_flag_i,
    input logic                 oc_flag_o,
    input logic [NCH-1:0]       oc_phase_o,
    input logic [NCH*RMS_W-1:0] cap_o,
    input logic                 irq_o
);
    logic past_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    // R8
    phase_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok |-> (($past(oc_phase_o) & ~$past(clr_phase_i) & ~oc_phase_o) == '0));

    // R4
    new_bit_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok |-> ((oc_phase_o & ~$past(oc_phase_o)
                      & ~($past(ch_en_i) & {NCH{$past(upd_vld_i)}})) == '0));

    // R2
    flag_with_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && ((oc_phase_o & ~$past(oc_phase_o)) != '0)) |-> oc_flag_o);

    // R6
    cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && !$past(upd_vld_i)) |-> (cap_o == $past(cap_o)));

    // R9
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && $past(clr_flag_i) && !$past(upd_vld_i)) |-> !oc_flag_o);

    // R11
    irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (irq_en_i && oc_flag_o));
endmodule

bind oc_monitor oc_monitor_chk #(.NCH(NCH), .RMS_W(RMS_W)) u_oc_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_vld_i   (upd_vld_i),
    .ch_en_i     (ch_en_i),
    .irq_en_i    (irq_en_i),
    .clr_phase_i (clr_phase_i),
    .clr_flag_i  (clr_flag_i),
    .oc_flag_o   (oc_flag_o),
    .oc_phase_o  (oc_phase_o),
    .cap_o       (cap_o),
    .irq_o       (irq_o)
);

// File: tb/test_oc_monitor.sv
`timescale 1ns/1ps
module test_oc_monitor;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        upd_vld_i = 1'b0;
    logic [95:0] rms_i = '0;
    logic [3:0]  ch_en_i = '0;
    logic [28:0] lim_i = '0;
    logic        irq_en_i = 1'b0;
    logic [3:0]  clr_phase_i = '0;
    logic        clr_flag_i = 1'b0;
    logic        oc_flag_o;
    logic [3:0]  oc_phase_o;
    logic [95:0] cap_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [3:0]  m_phase = '0;
    logic        m_flag = 1'b0;
    logic [23:0] m_cap [4] = '{default: '0};

    always #10 clk_i = ~clk_i;

    oc_monitor i_oc_monitor (
        .clk_i(clk_i), .rst_ni(rst_ni), .upd_vld_i(upd_vld_i), .rms_i(rms_i),
        .ch_en_i(ch_en_i), .lim_i(lim_i), .irq_en_i(irq_en_i),
        .clr_phase_i(clr_phase_i), .clr_flag_i(clr_flag_i),
        .oc_flag_o(oc_flag_o), .oc_phase_o(oc_phase_o), .cap_o(cap_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [3:0]  en;
        logic        vld;
        logic [4:0]  clr;   // bit 4 clears the flag, bits 3:0 the channel bits
        logic [23:0] r0, r1, r2, r3;
    } vec_t;

    localparam int NV = 9;
    // threshold for the table: lim = 1000 << 5
    localparam vec_t TBL [NV] = '{
        '{4'hF, 1'b1, 5'h00, 24'd500,  24'd500,  24'd500,  24'd500 },  // R5 quiet
        '{4'h1, 1'b1, 5'h00, 24'd1500, 24'd2000, 24'd2000, 24'd2000},  // R2 R4
        '{4'hF, 1'b1, 5'h00, 24'd900,  24'd900,  24'd900,  24'd900 },  // R8
        '{4'hF, 1'b0, 5'h00, 24'd5000, 24'd5000, 24'd5000, 24'd5000},  // R6
        '{4'hA, 1'b1, 5'h00, 24'd3000, 24'd3100, 24'd3200, 24'd3300},  // R4 R5
        '{4'hF, 1'b1, 5'h01, 24'd0,    24'd0,    24'd0,    24'd0   },  // R9
        '{4'h0, 1'b1, 5'h10, 24'd9000, 24'd9000, 24'd9000, 24'd9000},  // R4 R9
        '{4'h4, 1'b1, 5'h00, 24'd10,   24'd10,   24'd1001, 24'd10  },  // R2 boundary
        '{4'hF, 1'b1, 5'h1F, 24'd1000, 24'd1000, 24'd1000, 24'd1000}   // R3 R9
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] en, input logic vld, input logic [4:0] clr,
                         input logic [23:0] r0, input logic [23:0] r1,
                         input logic [23:0] r2, input logic [23:0] r3);
        logic [23:0] r [4];
        logic [3:0]  hit;
        logic [23:0] thr;
        r = '{r0, r1, r2, r3};
        thr = lim_i[28:5];
        ch_en_i = en; upd_vld_i = vld;
        clr_phase_i = clr[3:0]; clr_flag_i = clr[4];
        rms_i = {r3, r2, r1, r0};
        for (int i = 0; i < 4; i++) hit[i] = vld && en[i] && (r[i] > thr);
        m_phase = (m_phase & ~clr[3:0]) | hit;
        m_flag  = (m_flag & ~clr[4]) | (|hit);
        for (int i = 0; i < 4; i++) if (hit[i]) m_cap[i] = r[i];
        @(negedge clk_i);
        upd_vld_i = 1'b0; clr_phase_i = '0; clr_flag_i = 1'b0;
    endtask

    task automatic check_all(input string req);
        chk(req, "phase", 32'(oc_phase_o), 32'(m_phase));
        chk(req, "flag", 32'(oc_flag_o), 32'(m_flag));
        for (int i = 0; i < 4; i++) chk(req, "capture", 32'(cap_o[i*24 +: 24]), 32'(m_cap[i]));
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        lim_i = 29'(1000 << 5);
        repeat (3) @(negedge clk_i);
        // R1 while reset is held
        chk("R1", "flag in reset", 32'(oc_flag_o), 0);
        chk("R1", "phase in reset", 32'(oc_phase_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1", "irq after reset", 32'(irq_o), 0);
        check_all("R1");

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].en, TBL[k].vld, TBL[k].clr, TBL[k].r0, TBL[k].r1, TBL[k].r2, TBL[k].r3);
            check_all($sformatf("R2/R3/R4/R5/R6/R8/R9 row %0d", k));
        end

        // R7: low five bits of the limit are dropped
        lim_i = 29'((200 << 5) | 31);
        drive(4'hF, 1'b1, 5'h00, 24'd200, 24'd0, 24'd0, 24'd0);
        chk("R7", "no trip at 200", 32'(oc_phase_o), 0);
        drive(4'hF, 1'b1, 5'h00, 24'd201, 24'd0, 24'd0, 24'd0);
        chk("R7", "trip at 201", 32'(oc_phase_o), 1);
        chk("R7", "capture 201", 32'(cap_o[23:0]), 201);

        // R9 clear everything, then R10 clear and trip together
        drive(4'h0, 1'b0, 5'h1F, 24'd0, 24'd0, 24'd0, 24'd0);
        check_all("R9");
        drive(4'h1, 1'b1, 5'h00, 24'd400, 24'd0, 24'd0, 24'd0);
        drive(4'h1, 1'b1, 5'h11, 24'd300, 24'd0, 24'd0, 24'd0);
        chk("R10", "phase bit kept", 32'(oc_phase_o), 1);
        chk("R10", "flag kept", 32'(oc_flag_o), 1);
        chk("R10", "capture 300", 32'(cap_o[23:0]), 300);

        // R11 interrupt gating
        irq_en_i = 1'b0; #1;
        chk("R11", "irq disabled", 32'(irq_o), 0);
        irq_en_i = 1'b1; #1;
        chk("R11", "irq enabled", 32'(irq_o), 1);
        drive(4'h0, 1'b0, 5'h10, 24'd0, 24'd0, 24'd0, 24'd0);
        chk("R11", "irq after flag clear", 32'(irq_o), 0);
        check_all("R9/R11");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule